// File: doc/BRIEF.md
# Video memory write port with byte-fill engine

This block is the write side of a video controller's data port. A host writes 16-bit words to the port. Each accepted word goes to video memory at the current byte address. The address then moves forward by a programmed step. Writes that land on an odd byte address have their two bytes exchanged before they are stored.

The same path also serves a fill transfer. A configuration load sets the address, the step, a word count and a source counter, and it can arm fill mode. Once armed, the block waits and writes nothing on its own. The next host data write releases it. That write is stored like any other, and its upper byte becomes the fill byte. From the following clock on, the engine writes the fill byte doubled into both halves of a word, one word per clock. Each of these writes uses the same swap and address-step rules as a host write. Each fill write also moves the source counter up by one and the word count down by one. When the count runs out, the fill ends and the armed flag drops. Host writes are held off while the fill runs.

Top module: `vram_fill_port`

## Requirements
- R1: While reset is high and on the cycle after it, `vram_we`, `fill_busy` and `fill_active` are 0, and `port_ready` is 1 when `cfg_wr` is 0.
- R2: An accepted host write (`port_wr` high while `port_ready` is high) appears on the clock edge that accepts it. On that edge `vram_we` is 1 and `vram_addr` equals bits ADDR_W-1:1 of the current address. When address bit 0 is 0, `vram_wdata` equals `port_data` unchanged.
- R3: When address bit 0 is 1, the stored word is `{port_data[7:0], port_data[15:8]}`.
- R4: After every memory write, whether from the host or the fill engine, the address grows by the zero-extended `cfg_inc`, modulo 2^ADDR_W.
- R5: A `cfg_wr` with `cfg_fill`=1 sets `fill_active` and arms the fill. While armed, the engine makes no memory write and `fill_busy` stays 0.
- R6: The host write that releases an armed fill is itself stored to memory. Its upper byte is kept as the fill byte, and fill writes start on the next clock.
- R7: Each fill write stores the fill byte in both bytes of the word, at one write per clock.
- R8: Each fill write adds 1 to `dma_src` (wrapping) and takes 1 from the word count. After the write that brings the count to zero, `fill_busy` and `fill_active` both drop.
- R9: A word count of 0 loaded by `cfg_wr` yields 65536 fill writes (2^LEN_W).
- R10: `port_ready` is 0 while `fill_busy` is 1 or `cfg_wr` is 1. A `port_wr` offered then is not stored and does not move the address.
- R11: A `cfg_wr` during a running fill is ignored: the address, count, source counter and fill byte continue unchanged.
- R12: A `cfg_wr` with `cfg_fill`=0 loads the address and clears `fill_active`, which disarms a waiting fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load configuration this cycle |
| cfg_addr | input | ADDR_W | Start byte address |
| cfg_inc | input | INC_W | Address step after each write |
| cfg_len | input | LEN_W | Fill word count (0 means 2^LEN_W) |
| cfg_src | input | SRC_W | Start value of the source counter |
| cfg_fill | input | 1 | Arm fill mode with this load |
| port_wr | input | 1 | Host data write request |
| port_data | input | DATA_W | Host write data |
| port_ready | output | 1 | Host write accepted this cycle |
| vram_we | output | 1 | Memory write strobe |
| vram_addr | output | ADDR_W-1 | Memory word address |
| vram_wdata | output | DATA_W | Memory write data |
| fill_busy | output | 1 | Fill writes in progress |
| fill_active | output | 1 | Fill armed or running |
| dma_src | output | SRC_W | Source counter |

## Verification
Two events can meet on a single clock edge. The first is the host write that releases an armed fill, which is stored in the same cycle that the fill state is entered. The second is the last fill write, which lands on the same edge where the busy flag falls and `port_ready` comes back. The bench holds `port_wr` high throughout a fill, and it also pulses `cfg_wr` in the middle of a fill. A behavioural model tracks the address, count and fill byte and is compared against the ports on every clock. The match has to hold across the trigger cycle and the cycle the fill ends, with no write lost and none doubled.

// File: rtl/vfill_pkg.sv
package vfill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_WAIT = 2'd1,
    FS_RUN  = 2'd2
  } fill_state_t;
endpackage

// File: rtl/vfill_ctrl.sv
module vfill_ctrl
  import vfill_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_take,
  input  logic             cfg_fill,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic             cpu_take,
  input  logic [7:0]       cpu_hi,
  output logic             running,
  output logic             armed,
  output logic [7:0]       fill_byte,
  output logic [SRC_W-1:0] src_cnt
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  fill_state_t      state;
  logic [LEN_W-1:0] len_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= FS_IDLE;
      len_cnt   <= '0;
      src_cnt   <= '0;
      fill_byte <= '0;
      armed     <= 1'b0;
    end else if (state == FS_RUN) begin
      src_cnt <= src_cnt + SRC_W'(1);
      len_cnt <= len_cnt - LEN_ONE;
      if (len_cnt == LEN_ONE) begin
        state <= FS_IDLE;
        armed <= 1'b0;
      end
    end else if (cfg_take) begin
      len_cnt <= cfg_len;
      src_cnt <= cfg_src;
      armed   <= cfg_fill;
      state   <= cfg_fill ? FS_WAIT : FS_IDLE;
    end else if (cpu_take && state == FS_WAIT) begin
      fill_byte <= cpu_hi;
      state     <= FS_RUN;
    end
  end

  assign running = (state == FS_RUN);
endmodule

// File: rtl/vfill_addr.sv
module vfill_addr #(
  parameter int ADDR_W = 16,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic [INC_W-1:0]  inc,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [INC_W-1:0]  inc_q;
  logic [ADDR_W-1:0] inc_ext;

  assign inc_ext = ADDR_W'(inc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      inc_q <= '0;
    end else if (step) begin
      addr <= addr + inc_ext;
    end else if (load) begin
      addr  <= load_val;
      inc_q <= inc;
    end
  end
endmodule

// File: rtl/vfill_wpath.sv
module vfill_wpath #(
  parameter int DATA_W = 16
) (
  input  logic              use_fill,
  input  logic [7:0]        fill_byte,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              odd,
  output logic [DATA_W-1:0] word
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] fill_word;
  logic [DATA_W-1:0] src_word;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign fill_word[g*8 +: 8] = fill_byte;
      assign word[g*8 +: 8] = odd ? src_word[(LANES-1-g)*8 +: 8]
                                  : src_word[g*8 +: 8];
    end
  endgenerate

  assign src_word = use_fill ? fill_word : cpu_data;
endmodule

// File: rtl/vram_fill_port.sv
module vram_fill_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int INC_W  = 8,
  parameter int LEN_W  = 16,
  parameter int SRC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [INC_W-1:0]  cfg_inc,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [SRC_W-1:0]  cfg_src,
  input  logic              cfg_fill,
  input  logic              port_wr,
  input  logic [DATA_W-1:0] port_data,
  output logic              port_ready,
  output logic              vram_we,
  output logic [ADDR_W-2:0] vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic              fill_busy,
  output logic              fill_active,
  output logic [SRC_W-1:0]  dma_src
);
  logic              running;
  logic              cpu_take;
  logic              cfg_take;
  logic              step;
  logic [7:0]        fill_byte;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;

  assign port_ready = !running && !cfg_wr;
  assign cpu_take   = port_wr && port_ready;
  assign cfg_take   = cfg_wr && !running;
  assign step       = running || cpu_take;

  vfill_ctrl #(.LEN_W(LEN_W), .SRC_W(SRC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfg_take  (cfg_take),
    .cfg_fill  (cfg_fill),
    .cfg_len   (cfg_len),
    .cfg_src   (cfg_src),
    .cpu_take  (cpu_take),
    .cpu_hi    (port_data[DATA_W-1 -: 8]),
    .running   (running),
    .armed     (fill_active),
    .fill_byte (fill_byte),
    .src_cnt   (dma_src)
  );

  vfill_addr #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_take),
    .load_val (cfg_addr),
    .inc      (cfg_inc),
    .step     (step),
    .addr     (addr)
  );

  vfill_wpath #(.DATA_W(DATA_W)) u_wpath (
    .use_fill  (running),
    .fill_byte (fill_byte),
    .cpu_data  (port_data),
    .odd       (addr[0]),
    .word      (word)
  );

  assign fill_busy = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      vram_we    <= 1'b0;
      vram_addr  <= '0;
      vram_wdata <= '0;
    end else begin
      vram_we <= step;
      if (step) begin
        vram_addr  <= addr[ADDR_W-1:1];
        vram_wdata <= word;
      end
    end
  end
endmodule

// File: rtl/vfill_chk.sv
module vfill_chk #(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              port_wr,
  input logic              port_ready,
  input logic              vram_we,
  input logic [DATA_W-1:0] vram_wdata,
  input logic              fill_busy,
  input logic              fill_active,
  input logic [SRC_W-1:0]  dma_src
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!vram_we && !fill_busy && !fill_active));

  // R10
  stall_while_fill_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> !port_ready);

  // R7
  fill_write_each_clk_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |=> (vram_we && vram_wdata[DATA_W-1 -: 8] == vram_wdata[7:0]));

  // R8
  src_advance_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |=> dma_src == SRC_W'($past(dma_src) + SRC_W'(1)));

  // R8
  end_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fill_busy) |-> !fill_active);

  // R5
  armed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_active && !fill_busy && !(port_wr && port_ready)) |=> !vram_we);

  // R6
  busy_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> fill_active);
endmodule

bind vram_fill_port vfill_chk #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_wr     (port_wr),
  .port_ready  (port_ready),
  .vram_we     (vram_we),
  .vram_wdata  (vram_wdata),
  .fill_busy   (fill_busy),
  .fill_active (fill_active),
  .dma_src     (dma_src)
);

// File: tb/tb_vram_fill_port.sv
`timescale 1ns/100ps
module tb_vram_fill_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_fill = 0, port_wr = 0;
  logic [15:0] cfg_addr = 0, cfg_len = 0, cfg_src = 0, port_data = 0;
  logic [7:0]  cfg_inc = 0;
  logic        port_ready, vram_we, fill_busy, fill_active;
  logic [14:0] vram_addr;
  logic [15:0] vram_wdata, dma_src;

  vram_fill_port dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_inc(cfg_inc), .cfg_len(cfg_len), .cfg_src(cfg_src),
    .cfg_fill(cfg_fill), .port_wr(port_wr), .port_data(port_data),
    .port_ready(port_ready), .vram_we(vram_we), .vram_addr(vram_addr),
    .vram_wdata(vram_wdata), .fill_busy(fill_busy),
    .fill_active(fill_active), .dma_src(dma_src)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state: 0 idle, 1 armed, 2 filling
  int          m_st = 0;
  logic [15:0] m_addr = 0, m_len = 0, m_src = 0;
  logic [7:0]  m_inc = 0, m_fb = 0;
  logic        m_act = 0, m_we = 0;
  logic [14:0] m_waddr = 0;
  logic [15:0] m_wdata = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] swp(input logic [15:0] d, input logic odd);
    return odd ? {d[7:0], d[15:8]} : d;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_addr = 0; m_len = 0; m_src = 0; m_inc = 0; m_fb = 0;
      m_act = 0; m_we = 0; m_waddr = 0; m_wdata = 0;
    end else begin
      m_we = 0;
      if (m_st == 2) begin
        m_we = 1; m_waddr = m_addr[15:1]; m_wdata = swp({m_fb, m_fb}, m_addr[0]);
        m_addr = m_addr + 16'(m_inc);
        m_src = m_src + 16'd1;
        if (m_len == 16'd1) begin m_st = 0; m_act = 0; end
        m_len = m_len - 16'd1;
      end else if (cfg_wr) begin
        m_addr = cfg_addr; m_inc = cfg_inc; m_len = cfg_len; m_src = cfg_src;
        m_act = cfg_fill; m_st = cfg_fill ? 1 : 0;
      end else if (port_wr) begin
        m_we = 1; m_waddr = m_addr[15:1]; m_wdata = swp(port_data, m_addr[0]);
        m_addr = m_addr + 16'(m_inc);
        if (m_st == 1) begin m_fb = port_data[15:8]; m_st = 2; end
      end
    end
  end

  // per-clock comparison of registered outputs
  always @(negedge clk) begin
    chk(vram_we == m_we, "R2/R4 we", vram_we, m_we);
    chk(vram_addr == m_waddr, "R4 addr", vram_addr, m_waddr);
    chk(vram_wdata == m_wdata, "R3/R7 data", vram_wdata, m_wdata);
    chk(fill_busy == (m_st == 2), "R8 busy", fill_busy, m_st == 2);
    chk(fill_active == m_act, "R5/R12 active", fill_active, m_act);
    chk(dma_src == m_src, "R8 src", dma_src, m_src);
    #1;
    chk(port_ready == (m_st != 2 && !cfg_wr), "R10 ready", port_ready, m_st != 2 && !cfg_wr);
  end

  always @(posedge clk) begin
    if (cyc == 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  task automatic cfg(input logic [15:0] a, input logic [7:0] inc, input logic [15:0] len,
                     input logic [15:0] src, input logic fill);
    cfg_wr = 1; cfg_addr = a; cfg_inc = inc; cfg_len = len; cfg_src = src; cfg_fill = fill;
    tick();
    cfg_wr = 0; cfg_fill = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    port_wr = 1; port_data = d;
    tick();
    port_wr = 0;
  endtask

  initial begin
    tick(); tick(); tick();
    // R1: reset state
    chk(!vram_we && !fill_busy && !fill_active && port_ready, "R1 reset", vram_we, 0);
    rst = 0; tick();
    chk(!vram_we && !fill_busy && port_ready, "R1 after reset", fill_busy, 0);

    // R2: even address, no swap
    cfg(16'h0100, 8'd2, 16'd0, 16'd0, 1'b0);
    wr(16'h1234); wr(16'h5678);
    // R3: odd address swaps bytes
    cfg(16'h0201, 8'd2, 16'd0, 16'd0, 1'b0);
    wr(16'hABCD);
    // R4: address wraps
    cfg(16'hFFFE, 8'd4, 16'd0, 16'd0, 1'b0);
    wr(16'h1111); wr(16'h2222);

    // R5: armed fill stays quiet; R6 trigger write; R7/R8 fill body
    cfg(16'h1000, 8'd2, 16'd5, 16'hFFFE, 1'b1);
    tick(); tick(); tick();
    chk(fill_active && !fill_busy && !vram_we, "R5 armed quiet", vram_we, 0);
    port_wr = 1; port_data = 16'h5A11; tick();
    // R10: keep the host write pending through the fill
    port_data = 16'hEEEE; tick();
    // R11: configuration during fill is ignored
    cfg_wr = 1; cfg_addr = 16'h7777; cfg_len = 16'd9; cfg_src = 16'h4444; tick();
    cfg_wr = 0;
    while (fill_busy) tick();
    port_wr = 0; tick();
    chk(dma_src == 16'h0003, "R8 src wrap end", dma_src, 16'h0003);
    chk(!fill_active, "R8 active cleared", fill_active, 0);

    // R7: fill at odd address with swap path
    cfg(16'h2001, 8'd1, 16'd3, 16'd0, 1'b1);
    wr(16'hC300);
    while (fill_busy) tick();
    tick();
    chk(dma_src == 16'd3, "R7 three steps", dma_src, 3);

    // R12: non-fill configuration disarms
    cfg(16'h3000, 8'd2, 16'd4, 16'd0, 1'b1);
    cfg(16'h3000, 8'd2, 16'd4, 16'd0, 1'b0);
    wr(16'h9900); tick();
    chk(!fill_busy && !fill_active, "R12 disarm", fill_active, 0);

    // R9: zero length means 65536 writes
    cfg(16'h0000, 8'd2, 16'd0, 16'h1234, 1'b1);
    wr(16'h7700);
    for (int i = 0; i < 65535; i++) tick();
    chk(fill_busy, "R9 still busy", fill_busy, 1);
    tick(); tick();
    chk(!fill_busy && dma_src == 16'h1234, "R9 full wrap", dma_src, 16'h1234);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      port_wr = $urandom_range(0, 1); port_data = 16'($urandom);
      cfg_wr = ($urandom_range(0, 15) == 0);
      cfg_addr = 16'($urandom); cfg_inc = 8'($urandom_range(0, 5));
      cfg_len = 16'($urandom_range(1, 6)); cfg_src = 16'($urandom);
      cfg_fill = $urandom_range(0, 1);
      tick();
    end
    port_wr = 0; cfg_wr = 0;
    tick(); tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule